// File: doc/BRIEF.md
# Eight-Channel TDM Audio Serial Transmitter

This block turns a frame of eight parallel 24-bit audio samples into a single time-division-multiplexed serial line for a downstream converter. It is the clock master of the link. It makes the bit clock and the frame clock itself, dividing both down from its own clock `clk`. The default divide ratio is 2, so a 512 × fs master clock yields the 256 × fs bit clock needed for eight 32-cycle slots.

Samples enter through a valid/ready handshake. `in_ready` pulses for one `clk` cycle per frame, in the cycle just before a frame starts. `in_ready` never waits on `in_valid`. A producer may raise `in_valid` at any time and must hold `in_data` stable until a cycle in which both signals are high. If no sample set is offered at that moment, the block replays the last accepted set and reports an underrun. Back-pressure is therefore one acceptance per frame: a producer can be stalled for up to one frame period.

Six static configuration pins select the following:
- the slot length;
- the framing style (one-slot pulse or 50% clock);
- a one-bit data delay versus left-justified data;
- bit order;
- frame-clock polarity;
- the latching edge of the bit clock.

All configuration and the sample set are captured together at a frame boundary.

Top module: `tdm_tx`

## Requirements
- R1: With pulse framing, slot s (s = 0..7, counted from the frame edge) carries channel s+1. Channel c+1 is taken from `in_data[24*c +: 24]`.
- R2: `cfg_slot16` = 0 gives 32 bit-clock cycles per slot: the 24 sample bits, then 8 zero bits. `cfg_slot16` = 1 gives 16-cycle slots that carry the upper 16 sample bits (bits 23..8).
- R3: `cfg_lsb_first` = 0 sends the carried bits most significant first. A value of 1 sends them least significant first: bit 0 first for 32-cycle slots, bit 8 first for 16-cycle slots.
- R4: `cfg_lj` = 1 starts the first data bit at bit position 0 of the frame. `cfg_lj` = 0 delays all data by one bit-clock cycle, and bit position 0 then carries 0.
- R5: With `cfg_pulse_fs` = 1, `fs_o` is high for the first slot of each frame and low for the rest. `cfg_fs_inv` has no effect in this mode.
- R6: With `cfg_pulse_fs` = 0, `fs_o` is a 50% clock. With `cfg_fs_inv` = 0 it is low for the first half of the frame; with `cfg_fs_inv` = 1 the level is inverted. Slots 0..3 carry channels 1, 3, 5, 7 and slots 4..7 carry channels 2, 4, 6, 8.
- R7: `bclk_o` has a period of 2·HALF_DIV `clk` cycles. A frame holds exactly 8 × slot-length bit periods. With `cfg_fall_edge` = 0, `sd_o` and `fs_o` change on the falling edge of `bclk_o` and are sampled on the rising edge; a value of 1 swaps the two edges.
- R8: `in_ready` is high for exactly one `clk` cycle per frame, in the cycle before the frame's first bit is driven. A sample set is accepted when `in_valid` is high in that cycle.
- R9: If `in_valid` is low when `in_ready` is high, the previous sample set is sent again (all zero before the first acceptance). `underrun_o` is then high for exactly the next `clk` cycle, and it is low at every other time.
- R10: Configuration pins are sampled only in the `in_ready` cycle. Changes made mid-frame do not affect the frame in progress.
- R11: During reset and until the first frame starts, `fs_o`, `sd_o`, `in_ready` and `underrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Sample set taken this cycle (once per frame) |
| in_data | input | 192 | Eight 24-bit samples, channel 1 in the low bits |
| cfg_slot16 | input | 1 | 1: 16-cycle slots, 0: 32-cycle slots |
| cfg_pulse_fs | input | 1 | 1: one-slot pulse framing, 0: 50% framing |
| cfg_lj | input | 1 | 1: left-justified, 0: one-bit delay |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_fs_inv | input | 1 | Inverts the 50% frame clock |
| cfg_fall_edge | input | 1 | 1: receiver latches on the falling bit-clock edge |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame clock |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse when a frame replays old samples |

## Verification
The bench captures `sd_o` and `fs_o` on each latching edge of the bit clock and compares whole frames with a bench model.

Directed frames each change one knob away from a pulse, one-bit-delay, MSB-first, rising-edge baseline. This shows that every pin has its own effect:
- Pulse framing with the polarity pin set proves that polarity is ignored in that mode.
- An all-ones frame in 16-cycle, left-justified, LSB-first mode shows whether the truncated and padded bits fall in the right positions.

Randomised frames then mix all six pins, per-channel data and missing `in_valid`. Because the pins change mid-frame, they separate frame-boundary capture from live use of the pins. They also separate replay of the old samples from loss of them.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  // Frame configuration, captured as one word at every frame boundary.
  typedef struct packed {
    logic slot_short;  // 1: short slots
    logic pulse_fs;    // 1: one-slot frame pulse, 0: 50% frame clock
    logic no_delay;    // 1: first data bit on the frame edge
    logic lsb_first;   // 1: least significant bit first
    logic fs_invert;   // inverts the 50% frame clock
    logic latch_fall;  // 1: receiver samples on falling bit-clock edge
  } tdm_cfg_t;

endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen #(
  parameter int HALF_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_fall,
  output logic bclk_o,
  output logic launch
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // ph_q low = launch half, high = latch half of the bit period.
  assign launch = tick & ph_q;
  assign bclk_o = ph_q ^ latch_fall;

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_tx_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int SLOT_LONG  = 32,
  parameter int SLOT_SHORT = 16,
  localparam int FRAME_LONG = N_CH * SLOT_LONG,
  localparam int POS_W      = $clog2(FRAME_LONG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  tdm_cfg_t         cfg_in,
  output logic             frame_start,
  output logic             started,
  output tdm_cfg_t         cfg_q,
  output tdm_cfg_t         cfg_nx,
  output logic [POS_W-1:0] pos_nx
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_pos;
  logic             started_q;

  assign last_pos    = cfg_q.slot_short ? POS_W'(N_CH * SLOT_SHORT - 1)
                                        : POS_W'(FRAME_LONG - 1);
  assign frame_start = launch & (~started_q | (pos_q == last_pos));
  assign pos_nx      = frame_start ? '0 : pos_q + 1'b1;
  assign cfg_nx      = frame_start ? cfg_in : cfg_q;
  assign started     = started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      started_q <= 1'b0;
      cfg_q     <= '0;
    end else if (launch) begin
      pos_q     <= pos_nx;
      started_q <= 1'b1;
      cfg_q     <= cfg_nx;
    end
  end

endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux
  import tdm_tx_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int SAMPLE_W   = 24,
  parameter int SLOT_LONG  = 32,
  parameter int SLOT_SHORT = 16,
  localparam int POS_W = $clog2(N_CH * SLOT_LONG),
  localparam int DW    = N_CH * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             frame_start,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [POS_W-1:0] pos_nx,
  input  tdm_cfg_t         cfg_nx,
  output logic             sd_o,
  output logic             fs_o
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int SLL   = $clog2(SLOT_LONG);
  localparam int SSL   = $clog2(SLOT_SHORT);
  localparam int W_L   = (SAMPLE_W < SLOT_LONG)  ? SAMPLE_W : SLOT_LONG;
  localparam int W_S   = (SAMPLE_W < SLOT_SHORT) ? SAMPLE_W : SLOT_SHORT;
  localparam int IW    = ((SLL > $clog2(SAMPLE_W)) ? SLL : $clog2(SAMPLE_W)) + 1;

  logic [DW-1:0]       shadow_q;
  logic [DW-1:0]       shadow_nx;
  logic [SAMPLE_W-1:0] words [N_CH];

  assign shadow_nx = (frame_start && in_valid) ? in_data : shadow_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_word
    assign words[c] = shadow_nx[c*SAMPLE_W +: SAMPLE_W];
  end

  logic [POS_W-1:0]    dpos;
  logic                lead_zero;
  logic [CH_W-1:0]     slot;
  logic [CH_W-1:0]     ch;
  logic [IW-1:0]       k;
  logic [IW-1:0]       width;
  logic [IW-1:0]       idx;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] shifted;
  logic                in_word;
  logic                bit_nx;
  logic                fs_nx;
  logic [POS_W-1:0]    slot_len;
  logic [POS_W-1:0]    half_len;

  always_comb begin
    // data position after the optional one-bit delay
    dpos      = cfg_nx.no_delay ? pos_nx : pos_nx - 1'b1;
    lead_zero = ~cfg_nx.no_delay & (pos_nx == '0);

    if (cfg_nx.slot_short) begin
      slot  = dpos[SSL +: CH_W];
      k     = IW'(dpos[SSL-1:0]);
      width = IW'(W_S);
    end else begin
      slot  = dpos[SLL +: CH_W];
      k     = IW'(dpos[SLL-1:0]);
      width = IW'(W_L);
    end

    // 50% framing interleaves: first half odd channels, second half even
    if (cfg_nx.pulse_fs) ch = slot;
    else                 ch = {slot[CH_W-2:0], slot[CH_W-1]};

    word    = words[ch];
    in_word = (k < width);
    if (cfg_nx.lsb_first) idx = IW'(SAMPLE_W) - width + k;
    else                  idx = IW'(SAMPLE_W - 1) - k;
    shifted = word >> idx;
    bit_nx  = in_word & ~lead_zero & shifted[0];

    slot_len = cfg_nx.slot_short ? POS_W'(SLOT_SHORT) : POS_W'(SLOT_LONG);
    half_len = cfg_nx.slot_short ? POS_W'(N_CH * SLOT_SHORT / 2)
                                 : POS_W'(N_CH * SLOT_LONG / 2);
    if (cfg_nx.pulse_fs) fs_nx = (pos_nx < slot_len);
    else                 fs_nx = (pos_nx >= half_len) ^ cfg_nx.fs_invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      sd_o     <= 1'b0;
      fs_o     <= 1'b0;
    end else if (launch) begin
      shadow_q <= shadow_nx;
      sd_o     <= bit_nx;
      fs_o     <= fs_nx;
    end
  end

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int SAMPLE_W   = 24,
  parameter int SLOT_LONG  = 32,
  parameter int SLOT_SHORT = 16,
  parameter int HALF_DIV   = 1,
  localparam int DW    = N_CH * SAMPLE_W,
  localparam int POS_W = $clog2(N_CH * SLOT_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_slot16,
  input  logic          cfg_pulse_fs,
  input  logic          cfg_lj,
  input  logic          cfg_lsb_first,
  input  logic          cfg_fs_inv,
  input  logic          cfg_fall_edge,
  output logic          bclk_o,
  output logic          fs_o,
  output logic          sd_o,
  output logic          underrun_o
);
  tdm_cfg_t         cfg_in;
  tdm_cfg_t         cfg_q;
  tdm_cfg_t         cfg_nx;
  logic             launch;
  logic             frame_start;
  logic             started;
  logic [POS_W-1:0] pos_nx;
  logic             underrun_q;

  assign cfg_in = '{slot_short: cfg_slot16, pulse_fs: cfg_pulse_fs,
                    no_delay:   cfg_lj,     lsb_first: cfg_lsb_first,
                    fs_invert:  cfg_fs_inv, latch_fall: cfg_fall_edge};

  tdm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_fall (cfg_q.latch_fall),
    .bclk_o     (bclk_o),
    .launch     (launch)
  );

  tdm_framer #(.N_CH(N_CH), .SLOT_LONG(SLOT_LONG), .SLOT_SHORT(SLOT_SHORT)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .cfg_in      (cfg_in),
    .frame_start (frame_start),
    .started     (started),
    .cfg_q       (cfg_q),
    .cfg_nx      (cfg_nx),
    .pos_nx      (pos_nx)
  );

  tdm_slot_mux #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W), .SLOT_LONG(SLOT_LONG),
                 .SLOT_SHORT(SLOT_SHORT)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .pos_nx      (pos_nx),
    .cfg_nx      (cfg_nx),
    .sd_o        (sd_o),
    .fs_o        (fs_o)
  );

  assign in_ready = frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrun_q <= 1'b0;
    else        underrun_q <= frame_start & ~in_valid;
  end

  assign underrun_o = underrun_q;

endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk
  import tdm_tx_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     launch,
  input logic     in_ready,
  input logic     in_valid,
  input logic     underrun_o,
  input logic     sd_o,
  input logic     fs_o,
  input logic     started,
  input tdm_cfg_t cfg_q
);
  // R7
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(launch) |-> ($stable(sd_o) && $stable(fs_o)));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> $past(in_ready && !in_valid));

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_ready) |-> $stable(cfg_q));

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!fs_o && !sd_o && !underrun_o));

endmodule

bind tdm_tx tdm_tx_chk u_tdm_tx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .launch     (launch),
  .in_ready   (in_ready),
  .in_valid   (in_valid),
  .underrun_o (underrun_o),
  .sd_o       (sd_o),
  .fs_o       (fs_o),
  .started    (started),
  .cfg_q      (cfg_q)
);

// File: tb/tdm_tx_bench.sv
module tdm_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int SW  = 24;
  localparam int DW  = NCH * SW;
  localparam int HDIV = 1;
  localparam int NFRAMES = 40;

  typedef struct packed {
    logic slot16, pulse, lj, lsb, inv, fall;
  } bcfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  bcfg_t cur = '0;
  logic bclk_o, fs_o, sd_o, underrun_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_tx u_tdm_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_slot16(cur.slot16), .cfg_pulse_fs(cur.pulse),
    .cfg_lj(cur.lj), .cfg_lsb_first(cur.lsb), .cfg_fs_inv(cur.inv),
    .cfg_fall_edge(cur.fall), .bclk_o(bclk_o), .fs_o(fs_o), .sd_o(sd_o),
    .underrun_o(underrun_o)
  );

  function automatic int slen(bcfg_t c);
    return c.slot16 ? 16 : 32;
  endfunction

  // expected data bit at frame position p
  function automatic logic exp_sd(int p, bcfg_t c, logic [DW-1:0] s);
    int len = slen(c);
    int q, slot, k, ch, w;
    if (!c.lj) begin
      if (p == 0) return 1'b0;
      q = p - 1;
    end else q = p;
    slot = q / len;
    k    = q % len;
    if (c.pulse) ch = slot;
    else ch = (slot < NCH/2) ? 2*slot : 2*(slot - NCH/2) + 1;
    w = (len < SW) ? len : SW;
    if (k >= w) return 1'b0;
    return c.lsb ? s[ch*SW + SW - w + k] : s[ch*SW + SW - 1 - k];
  endfunction

  function automatic logic exp_fs(int p, bcfg_t c);
    int len = slen(c);
    if (c.pulse) return (p < len);
    return (p >= len*NCH/2) ^ c.inv;
  endfunction

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic set_stim(input int k);
    logic [DW-1:0] d;
    for (int c = 0; c < NCH; c++)
      d[c*SW +: SW] = (24'(c + 1) << 20) | (24'h5A3C1 ^ 24'(k * 77));
    in_valid = 1'b1;
    case (k)
      0: cur = '{0,1,0,0,0,0};
      1: begin cur = '{0,1,0,0,0,0}; in_valid = 1'b0; end
      2: cur = '{0,1,1,0,0,0};
      3: cur = '{0,1,0,1,0,0};
      4: cur = '{1,1,0,0,0,0};
      5: cur = '{0,0,0,0,0,0};
      6: cur = '{0,0,0,0,1,0};
      7: cur = '{0,1,0,0,0,1};
      8: cur = '{0,1,0,0,1,0};
      9: begin cur = '{1,1,1,1,0,1}; d = '1; end
      default: begin
        cur = bcfg_t'($urandom % 64);
        for (int c = 0; c < NCH; c++) d[c*SW +: SW] = 24'($urandom);
        in_valid = (($urandom % 5) != 0);
      end
    endcase
    in_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bcfg_t act;
    logic [DW-1:0] exp_s;
    logic [255:0] cap_sd, cap_fs, e_sd, e_fs;
    int nbits, frames, k, cyc, last_latch;
    bit active, pend, chk_ur, chk_rdy, exp_ur, gap_bad, prev_b;

    void'($urandom(32'd4242));
    act = '0; exp_s = '0; cap_sd = '0; cap_fs = '0;
    nbits = 0; frames = 0; k = 0; cyc = 0; last_latch = -1;
    active = 0; pend = 0; chk_ur = 0; chk_rdy = 0; exp_ur = 0; gap_bad = 0;

    set_stim(0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!fs_o && !sd_o && !in_ready && !underrun_o,
          $sformatf("R11 reset outputs fs=%b sd=%b rdy=%b ur=%b exp 0000",
                    fs_o, sd_o, in_ready, underrun_o));
    rst_n = 1'b1;
    prev_b = bclk_o;

    while (frames < NFRAMES) begin
      @(negedge clk);
      cyc++;
      if (!active)
        // R11 held low before the first frame
        check(!fs_o && !sd_o, $sformatf("R11 idle fs=%b sd=%b exp 00", fs_o, sd_o));
      if (pend) begin
        k++;
        set_stim(k);
        pend = 0;
      end
      if (chk_ur) begin
        check(underrun_o == exp_ur,
              $sformatf("R9 underrun got %b exp %b", underrun_o, exp_ur));
        chk_ur = 0;
      end else if (underrun_o) begin
        check(1'b0, "R9 spurious underrun got 1 exp 0");
      end
      if (chk_rdy) begin
        check(!in_ready, $sformatf("R8 ready width got %b exp 0", in_ready));
        chk_rdy = 0;
      end
      // capture on the latching edge of the active frame's configuration
      if (active && bclk_o != prev_b && bclk_o == !act.fall) begin
        if (nbits < 256) begin
          cap_sd[nbits] = sd_o;
          cap_fs[nbits] = fs_o;
        end
        if (last_latch >= 0 && (cyc - last_latch) != 2*HDIV) gap_bad = 1;
        last_latch = cyc;
        nbits++;
      end
      prev_b = bclk_o;

      if (in_ready) begin
        if (active) begin
          e_sd = '0; e_fs = '0;
          for (int p = 0; p < slen(act)*NCH; p++) begin
            e_sd[p] = exp_sd(p, act, exp_s);
            e_fs[p] = exp_fs(p, act);
          end
          // R7 frame length and bit period
          check(nbits == slen(act)*NCH && !gap_bad,
                $sformatf("R7 frame %0d bits got %0d exp %0d gap_bad=%b",
                          frames, nbits, slen(act)*NCH, gap_bad));
          // R1 R2 R3 R4 R6 R10 data
          check(cap_sd == e_sd,
                $sformatf("R1 R2 R3 R4 R6 R10 data frame %0d cfg %b got %h exp %h",
                          frames, act, cap_sd, e_sd));
          // R5 R6 R10 frame clock
          check(cap_fs == e_fs,
                $sformatf("R5 R6 R10 sync frame %0d cfg %b got %h exp %h",
                          frames, act, cap_fs, e_fs));
          frames++;
        end
        act = cur;
        if (in_valid) exp_s = in_data;
        exp_ur = !in_valid;
        chk_ur = 1; chk_rdy = 1; pend = 1;
        active = 1; nbits = 0; gap_bad = 0;
        cap_sd = '0; cap_fs = '0;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule